// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block chooses the reply of a low-speed USB function to every transaction aimed at its three endpoints. Framing, line coding and CRC checking happen elsewhere. The block receives:

- one-cycle strobes for decoded tokens (kind, 7-bit address, endpoint number);
- a strobe for each received data packet, carrying its CRC verdict, data PID and byte count;
- a strobe when the host acknowledges data the device sent.

From these inputs it emits a handshake code, or a request to transmit an endpoint's IN buffer, or nothing at all.

A local processor configures the block through a small write port: endpoint enables, stall bits, the device address, and a mask that flushes IN buffers. It loads IN buffers by announcing their byte count, and it releases the single OUT buffer by signalling that it has read it. The block tracks buffer state and reports the following to the processor:

- an OUT-done flag and per-endpoint IN-done flags;
- a setup flag;
- the DATA0/DATA1 toggle, source endpoint and length of the last accepted OUT packet.

The rules for SETUP differ from those for OUT. A SETUP cannot be refused with NAK or STALL. It releases the endpoint-0 stalls and discards all pending IN data. While the OUT buffer is unread, a SETUP gets no reply and an OUT gets NAK.

Top module: `usb_ep_responder`

## Requirements
- R1: Out of reset, and until the first `bus_reset` pulse, no token gets any reply (no `hs_valid`, no `send_req`). Every processor write is ignored in that period. All status outputs read zero after reset.
- R2: A `bus_reset` pulse does the following:
  - sets the device address to 0;
  - enables endpoint 0 in both directions;
  - disables endpoints 1 and 2 and clears all stall bits;
  - empties every buffer.
- R3: A token gets a reply only when all of these hold:
  - its address equals the device address register (processor write with `cpu_sel`=2, value in `cpu_wdata[6:0]`);
  - its endpoint number is below 3;
  - the endpoint is enabled for that direction.

  Endpoint-1/2 enables are written with `cpu_sel`=0: IN enable of endpoint i in bit i, OUT enable in bit 4+i. Any other token is answered with silence.
- R4: An IN token (`tok_kind`=01) reaches an enabled endpoint whose buffer is loaded. One clock after the token, `send_req` pulses with that endpoint and the loaded byte count. If the buffer is empty, the reply is NAK instead (`hs_code` 01; ACK is 00, STALL is 10).
- R5: A `host_ack` after data was sent empties that IN buffer and sets its `in_done` bit. A new load of that endpoint clears the bit. A zero-length load is sent as a 0-byte packet and keeps the buffer occupied until acknowledged.
- R6: Stall bits are written with `cpu_sel`=1:
  - bit 0 stalls endpoint-0 IN and applies to IN tokens only;
  - bit 4 stalls endpoint-0 OUT and applies to OUT tokens only, never to SETUP;
  - bits 1 and 2 stall endpoints 1 and 2 for both directions, but only for a direction that is enabled.

  A stalled endpoint replies STALL. The stall takes precedence over loaded data.
- R7: A SETUP token (`tok_kind`=10) to endpoint 0 clears both endpoint-0 stall bits and flushes every IN buffer. It is never answered with NAK or STALL. When its data is accepted, the reply is ACK and `setup_flag` is set.
- R8: While `out_done` is set (OUT buffer unread), SETUP data gets no handshake and OUT data (`tok_kind`=00) gets NAK. In both cases the stored packet is unchanged. An `out_read` pulse clears `out_done` and `setup_flag`.
- R9: For SETUP and OUT, the reply comes one clock after the data strobe. `out_done` rises only together with an ACK for a data packet with good CRC. A data packet with bad CRC gets no handshake and stores nothing.
- R10: An accepted OUT or SETUP packet latches three things:
  - `toggle_out` (1 for DATA1);
  - `out_src` (00 endpoint 0, 01 endpoint 1, 10 endpoint 2);
  - `out_len`, where a count above 8 reads as 8.
- R11: A processor flush (`cpu_sel`=3, bit i for endpoint i) empties the selected IN buffers only, so later IN tokens to them get NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Pulse: USB bus reset detected |
| tok_valid | input | 1 | Pulse: decoded token present |
| tok_kind | input | 2 | 00 OUT, 01 IN, 10 SETUP |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 2 | Token endpoint number |
| dat_valid | input | 1 | Pulse: end of a received data packet |
| dat_crc_ok | input | 1 | Received packet CRC good |
| dat_pid1 | input | 1 | Received packet was DATA1 |
| dat_len | input | 4 | Received byte count |
| host_ack | input | 1 | Pulse: host ACK after device data |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_sel | input | 2 | 0 enables, 1 stalls, 2 address, 3 IN flush |
| cpu_wdata | input | 8 | Processor write data |
| in_load | input | 1 | Pulse: processor filled an IN buffer |
| in_load_ep | input | 2 | Endpoint of the filled IN buffer |
| in_load_len | input | 4 | Byte count of the filled IN buffer |
| out_read | input | 1 | Pulse: processor read the OUT buffer |
| hs_valid | output | 1 | Pulse: send the handshake in hs_code |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |
| send_req | output | 1 | Pulse: transmit an IN buffer |
| send_ep | output | 2 | Endpoint to transmit |
| send_len | output | 4 | Byte count to transmit |
| out_done | output | 1 | OUT buffer holds unread data |
| in_done | output | 3 | Per-endpoint IN data acknowledged |
| setup_flag | output | 1 | OUT buffer contents came from SETUP |
| toggle_out | output | 1 | Data PID of last accepted packet |
| out_src | output | 2 | Endpoint of last accepted packet |
| out_len | output | 4 | Byte count of last accepted packet |

## Verification
The bench builds the block with its default parameters: three endpoints, a 7-bit address and an 8-byte packet limit. With three endpoints, endpoint number 3 is a legal token value that maps to no endpoint, which exercises the silent-reply path. The 4-bit count with an 8-byte limit lets the bench send both zero-length packets and oversize counts that must saturate. Every stall, busy and flush path is driven across endpoints 0, 1 and 2, including a stall on a direction left disabled.

// File: rtl/usb_resp_pkg.sv
// Shared encodings for the endpoint handshake responder.
// Assumes: token and handshake codes are fixed by the port contract.
package usb_resp_pkg;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'b00,
        TOK_IN    = 2'b01,
        TOK_SETUP = 2'b10
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_code_e;

    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_STALL  = 2'd1;
    localparam logic [1:0] SEL_ADDR   = 2'd2;
    localparam logic [1:0] SEL_FLUSH  = 2'd3;

endpackage

// File: rtl/usb_resp_cfg.sv
// Processor-visible configuration: device address, endpoint enables and
// stall bits. Assumes at most four endpoints (enable/stall bit layout) and
// an address no wider than the 8-bit write bus. Writes are ignored until the
// first bus reset arms the block; a bus reset restores endpoint-0 only.
module usb_resp_cfg #(
    parameter int NUM_EP = 3,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_sel,
    input  logic [7:0]        cpu_wdata,
    input  logic              setup_seen,
    output logic              armed,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [NUM_EP-1:0] en_in,
    output logic [NUM_EP-1:0] en_out,
    output logic [NUM_EP-1:0] stall_in,
    output logic [NUM_EP-1:0] stall_out,
    output logic [NUM_EP-1:0] flush_req
);
    import usb_resp_pkg::*;

    localparam logic [NUM_EP-1:0] EP0_ONLY = NUM_EP'(1);

    logic wr_ok;
    logic unused_wdata;

    assign wr_ok        = armed && cpu_wr;
    assign unused_wdata = ^cpu_wdata;

    // Flush pulse toward the IN buffers, one bit per endpoint.
    always_comb begin
        flush_req = '0;
        if (wr_ok && cpu_sel == SEL_FLUSH) begin
            flush_req = cpu_wdata[NUM_EP-1:0];
        end
    end

    // Configuration registers with bus-reset defaults and SETUP stall release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            dev_addr  <= '0;
            en_in     <= '0;
            en_out    <= '0;
            stall_in  <= '0;
            stall_out <= '0;
        end else if (bus_reset) begin
            armed     <= 1'b1;
            dev_addr  <= '0;
            en_in     <= EP0_ONLY;
            en_out    <= EP0_ONLY;
            stall_in  <= '0;
            stall_out <= '0;
        end else begin
            if (wr_ok) begin
                case (cpu_sel)
                    SEL_ENABLE: begin
                        for (int i = 1; i < NUM_EP; i++) begin
                            en_in[i]  <= cpu_wdata[i];
                            en_out[i] <= cpu_wdata[4+i];
                        end
                    end
                    SEL_STALL: begin
                        stall_in[0]  <= cpu_wdata[0];
                        stall_out[0] <= cpu_wdata[4];
                        for (int i = 1; i < NUM_EP; i++) begin
                            stall_in[i]  <= cpu_wdata[i];
                            stall_out[i] <= cpu_wdata[i];
                        end
                    end
                    SEL_ADDR: dev_addr <= cpu_wdata[ADDR_W-1:0];
                    default: ;
                endcase
            end
            if (setup_seen) begin
                stall_in[0]  <= 1'b0;
                stall_out[0] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/usb_resp_in_slot.sv
// State of one IN buffer: occupied flag, byte count and done flag.
// Assumes a load and an acknowledge never target the slot in the same cycle;
// if they do, the load wins. Flush empties without setting done.
module usb_resp_in_slot #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             flush,
    input  logic             acked,
    output logic             full,
    output logic [LEN_W-1:0] len,
    output logic             done
);

    // Occupancy and completion tracking for this endpoint.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            full <= 1'b0;
            len  <= '0;
            done <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
            len  <= load_len;
            done <= 1'b0;
        end else if (acked) begin
            full <= 1'b0;
            done <= 1'b1;
        end else if (flush) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_resp_out_path.sv
// OUT/SETUP path: fixes the verdict when the token arrives and issues it when
// a good data packet follows. Owns the single OUT buffer status. Assumes the
// token and data strobes of one transaction come in separate cycles.
module usb_resp_out_path #(
    parameter int NUM_EP  = 3,
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8,
    parameter int EP_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             tok_valid,
    input  logic             arm_out,
    input  logic             arm_setup,
    input  logic [EP_W-1:0]  arm_ep,
    input  logic             arm_stall,
    input  logic             dat_valid,
    input  logic             dat_crc_ok,
    input  logic             dat_pid1,
    input  logic [LEN_W-1:0] dat_len,
    input  logic             out_read,
    output logic             hs_fire,
    output logic [1:0]       hs_code,
    output logic             pend_setup_live,
    output logic             out_full,
    output logic             setup_flag,
    output logic             toggle_out,
    output logic [EP_W-1:0]  out_src,
    output logic [LEN_W-1:0] out_len
);
    import usb_resp_pkg::*;

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    logic             pend_valid;
    logic             pend_setup;
    logic             pend_silent;
    logic             pend_accept;
    logic [1:0]       pend_code;
    logic [EP_W-1:0]  pend_ep;
    logic             good;
    logic [LEN_W-1:0] len_sat;

    assign good            = dat_valid && dat_crc_ok && pend_valid;
    assign hs_fire         = good && !pend_silent;
    assign hs_code         = pend_code;
    assign pend_setup_live = pend_valid && pend_setup;
    assign len_sat         = (dat_len > LEN_CAP) ? LEN_CAP : dat_len;

    // Verdict capture at token time, consumed by the next data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            pend_valid  <= 1'b0;
            pend_setup  <= 1'b0;
            pend_silent <= 1'b0;
            pend_accept <= 1'b0;
            pend_code   <= HS_ACK;
            pend_ep     <= '0;
        end else if (tok_valid) begin
            pend_valid <= arm_out || arm_setup;
            pend_setup <= arm_setup;
            pend_ep    <= arm_ep;
            if (arm_setup) begin
                pend_silent <= out_full;
                pend_accept <= !out_full;
                pend_code   <= HS_ACK;
            end else if (arm_stall) begin
                pend_silent <= 1'b0;
                pend_accept <= 1'b0;
                pend_code   <= HS_STALL;
            end else if (out_full) begin
                pend_silent <= 1'b0;
                pend_accept <= 1'b0;
                pend_code   <= HS_NAK;
            end else begin
                pend_silent <= 1'b0;
                pend_accept <= 1'b1;
                pend_code   <= HS_ACK;
            end
        end else if (dat_valid) begin
            pend_valid <= 1'b0;
        end
    end

    // OUT buffer status and the attributes of the last accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            out_full   <= 1'b0;
            setup_flag <= 1'b0;
            toggle_out <= 1'b0;
            out_src    <= '0;
            out_len    <= '0;
        end else if (good && pend_accept) begin
            out_full   <= 1'b1;
            setup_flag <= pend_setup;
            toggle_out <= dat_pid1;
            out_src    <= pend_ep;
            out_len    <= len_sat;
        end else if (out_read) begin
            out_full   <= 1'b0;
            setup_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_ep_responder.sv
// Top of the endpoint handshake responder. Decodes token strobes against the
// address and enables, answers IN tokens directly, delegates OUT/SETUP to the
// OUT path and registers a single handshake or send request per cycle.
// Assumes decoded, CRC-checked strobes and at most one strobe kind per cycle.
module usb_ep_responder #(
    parameter int NUM_EP  = 3,
    parameter int ADDR_W  = 7,
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8,
    localparam int EP_W   = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              dat_valid,
    input  logic              dat_crc_ok,
    input  logic              dat_pid1,
    input  logic [LEN_W-1:0]  dat_len,
    input  logic              host_ack,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_sel,
    input  logic [7:0]        cpu_wdata,
    input  logic              in_load,
    input  logic [EP_W-1:0]   in_load_ep,
    input  logic [LEN_W-1:0]  in_load_len,
    input  logic              out_read,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              send_req,
    output logic [EP_W-1:0]   send_ep,
    output logic [LEN_W-1:0]  send_len,
    output logic              out_done,
    output logic [NUM_EP-1:0] in_done,
    output logic              setup_flag,
    output logic              toggle_out,
    output logic [EP_W-1:0]   out_src,
    output logic [LEN_W-1:0]  out_len
);
    import usb_resp_pkg::*;

    localparam logic [EP_W:0]    EP_LIM  = (EP_W+1)'(NUM_EP);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    logic              armed;
    logic [ADDR_W-1:0] dev_addr;
    logic [NUM_EP-1:0] en_in, en_out, stall_in, stall_out, flush_req;
    logic [NUM_EP-1:0] in_full, slot_load, slot_flush, slot_ack;
    logic [LEN_W-1:0]  in_len [NUM_EP];
    logic [LEN_W-1:0]  load_sat;
    logic              tok_hit, ep_ok, is_in, arm_out, arm_setup, arm_stall;
    logic              in_stall_sel, in_full_sel;
    logic              out_hs_fire;
    logic [1:0]        out_hs_code;
    logic              out_pend_setup;
    logic              in_pend;
    logic [EP_W-1:0]   in_pend_ep;

    // Token qualification against address, endpoint range and enables.
    always_comb begin
        ep_ok        = ({1'b0, tok_ep} < EP_LIM);
        tok_hit      = tok_valid && armed && ep_ok && (tok_addr == dev_addr);
        is_in        = tok_hit && tok_kind == TOK_IN  && en_in[tok_ep];
        arm_out      = tok_hit && tok_kind == TOK_OUT && en_out[tok_ep];
        arm_setup    = tok_hit && tok_kind == TOK_SETUP && tok_ep == '0 && en_out[0];
        arm_stall    = ep_ok && stall_out[tok_ep];
        in_stall_sel = ep_ok && stall_in[tok_ep];
        in_full_sel  = ep_ok && in_full[tok_ep];
        load_sat     = (in_load_len > LEN_CAP) ? LEN_CAP : in_load_len;
    end

    usb_resp_cfg #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .setup_seen(arm_setup), .armed(armed), .dev_addr(dev_addr),
        .en_in(en_in), .en_out(en_out), .stall_in(stall_in),
        .stall_out(stall_out), .flush_req(flush_req)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_in
        assign slot_load[i]  = in_load && in_load_ep == EP_W'(i);
        assign slot_flush[i] = arm_setup || flush_req[i];
        assign slot_ack[i]   = host_ack && in_pend && in_pend_ep == EP_W'(i);

        usb_resp_in_slot #(.LEN_W(LEN_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .clear(bus_reset),
            .load(slot_load[i]), .load_len(load_sat),
            .flush(slot_flush[i]), .acked(slot_ack[i]),
            .full(in_full[i]), .len(in_len[i]), .done(in_done[i])
        );
    end

    usb_resp_out_path #(
        .NUM_EP(NUM_EP), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .EP_W(EP_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .tok_valid(tok_valid), .arm_out(arm_out), .arm_setup(arm_setup),
        .arm_ep(tok_ep), .arm_stall(arm_stall),
        .dat_valid(dat_valid), .dat_crc_ok(dat_crc_ok),
        .dat_pid1(dat_pid1), .dat_len(dat_len), .out_read(out_read),
        .hs_fire(out_hs_fire), .hs_code(out_hs_code),
        .pend_setup_live(out_pend_setup), .out_full(out_done),
        .setup_flag(setup_flag), .toggle_out(toggle_out),
        .out_src(out_src), .out_len(out_len)
    );

    // Registered reply: OUT/SETUP handshake, IN handshake or send request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_ACK;
            send_req <= 1'b0;
            send_ep  <= '0;
            send_len <= '0;
        end else begin
            hs_valid <= 1'b0;
            send_req <= 1'b0;
            if (out_hs_fire) begin
                hs_valid <= 1'b1;
                hs_code  <= out_hs_code;
            end else if (is_in) begin
                if (in_stall_sel) begin
                    hs_valid <= 1'b1;
                    hs_code  <= HS_STALL;
                end else if (in_full_sel) begin
                    send_req <= 1'b1;
                    send_ep  <= tok_ep;
                    send_len <= in_len[tok_ep];
                end else begin
                    hs_valid <= 1'b1;
                    hs_code  <= HS_NAK;
                end
            end
        end
    end

    // Remembers which IN endpoint awaits the host acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            in_pend    <= 1'b0;
            in_pend_ep <= '0;
        end else if (tok_valid) begin
            in_pend    <= is_in && !in_stall_sel && in_full_sel;
            in_pend_ep <= tok_ep;
        end else if (host_ack) begin
            in_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_resp_checks.sv
// Protocol checker for the responder, bound to the top module.
// Assumes the same one-strobe-per-cycle input discipline as the design.
module usb_resp_checks #(
    parameter int NUM_EP = 3,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [ADDR_W-1:0] tok_addr,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              armed,
    input logic              dat_valid,
    input logic              dat_crc_ok,
    input logic              host_ack,
    input logic              out_pend_setup,
    input logic              hs_valid,
    input logic [1:0]        hs_code,
    input logic              send_req,
    input logic              out_done,
    input logic [NUM_EP-1:0] in_done
);

    a_r4_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_valid && send_req));

    a_r1_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !dat_valid && !armed) |=> (!hs_valid && !send_req));

    a_r3_addr_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !dat_valid && tok_addr != dev_addr) |=> (!hs_valid && !send_req));

    a_r7_setup_not_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_crc_ok && out_pend_setup) |=> !(hs_valid && hs_code != 2'b00));

    a_r9_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_done) |-> (hs_valid && hs_code == 2'b00));

    a_r9_bad_crc_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && !dat_crc_ok && !tok_valid) |=> !hs_valid);

    a_r5_in_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(in_done) > $countones($past(in_done))) |-> $past(host_ack));

endmodule

bind usb_ep_responder usb_resp_checks #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_addr(tok_addr),
    .dev_addr(dev_addr), .armed(armed), .dat_valid(dat_valid),
    .dat_crc_ok(dat_crc_ok), .host_ack(host_ack),
    .out_pend_setup(out_pend_setup), .hs_valid(hs_valid), .hs_code(hs_code),
    .send_req(send_req), .out_done(out_done), .in_done(in_done)
);

// File: tb/tb_usb_ep_responder.sv
// Directed bench for the endpoint handshake responder.
module tb_usb_ep_responder;

    localparam int NUM_EP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'b00;
    logic [6:0] tok_addr = '0;
    logic [1:0] tok_ep = '0;
    logic       dat_valid = 1'b0;
    logic       dat_crc_ok = 1'b0;
    logic       dat_pid1 = 1'b0;
    logic [3:0] dat_len = '0;
    logic       host_ack = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_sel = '0;
    logic [7:0] cpu_wdata = '0;
    logic       in_load = 1'b0;
    logic [1:0] in_load_ep = '0;
    logic [3:0] in_load_len = '0;
    logic       out_read = 1'b0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       send_req;
    logic [1:0] send_ep;
    logic [3:0] send_len;
    logic       out_done;
    logic [2:0] in_done;
    logic       setup_flag;
    logic       toggle_out;
    logic [1:0] out_src;
    logic [3:0] out_len;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [1:0] K_OUT = 2'b00, K_IN = 2'b01, K_SETUP = 2'b10;
    localparam int ACK = 0, NAK = 1, STALL = 2, NONE = 3;

    usb_ep_responder dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reply seen at the ports: NONE, SEND(=4) or a handshake code.
    function automatic int reply();
        if (send_req) return 4;
        if (hs_valid) return int'(hs_code);
        return NONE;
    endfunction

    task automatic token(logic [1:0] k, logic [6:0] a, logic [1:0] e);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = k; tok_addr = a; tok_ep = e;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic data(logic crc, logic pid1, logic [3:0] len);
        @(negedge clk);
        dat_valid = 1'b1; dat_crc_ok = crc; dat_pid1 = pid1; dat_len = len;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic cpu_write(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic load_in(logic [1:0] e, logic [3:0] len);
        @(negedge clk);
        in_load = 1'b1; in_load_ep = e; in_load_len = len;
        @(negedge clk);
        in_load = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); out_read = 1'b1;
        @(negedge clk); out_read = 1'b0;
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    // OUT or SETUP transaction, returns the reply to the data packet.
    task automatic out_xact(logic [1:0] k, logic [6:0] a, logic [1:0] e,
                            logic crc, logic pid1, logic [3:0] len, output int r);
        token(k, a, e);
        chk("R9", "no reply before data", reply(), NONE);
        data(crc, pid1, len);
        r = reply();
    endtask

    task automatic t_reset_and_unarmed();
        int r;
        chk("R1", "reset out_done", out_done, 0);
        chk("R1", "reset in_done", in_done, 0);
        chk("R1", "reset setup_flag", setup_flag, 0);
        chk("R1", "reset reply", reply(), NONE);
        cpu_write(2'd2, 8'h05);
        token(K_IN, 7'd0, 2'd0);
        chk("R1", "IN before bus reset", reply(), NONE);
        token(K_IN, 7'd5, 2'd0);
        chk("R1", "address write ignored", reply(), NONE);
        out_xact(K_OUT, 7'd0, 2'd0, 1'b1, 1'b0, 4'd1, r);
        chk("R1", "OUT before bus reset", r, NONE);
    endtask

    task automatic t_bus_reset_and_address();
        pulse_bus_reset();
        token(K_IN, 7'd0, 2'd0);
        chk("R2", "EP0 IN enabled, addr 0, empty", reply(), NAK);
        token(K_IN, 7'd0, 2'd1);
        chk("R2", "EP1 IN disabled", reply(), NONE);
        cpu_write(2'd2, 8'h2A);
        token(K_IN, 7'd0, 2'd0);
        chk("R3", "old address ignored", reply(), NONE);
        token(K_IN, 7'h2A, 2'd0);
        chk("R3", "new address answered", reply(), NAK);
        token(K_IN, 7'h2A, 2'd3);
        chk("R3", "endpoint 3 silent", reply(), NONE);
    endtask

    task automatic t_in_data();
        load_in(2'd0, 4'd3);
        token(K_IN, 7'h2A, 2'd0);
        chk("R4", "send_req", reply(), 4);
        chk("R4", "send_ep", send_ep, 0);
        chk("R4", "send_len", send_len, 3);
        pulse_ack();
        chk("R5", "in_done after ack", in_done, 3'b001);
        token(K_IN, 7'h2A, 2'd0);
        chk("R5", "released buffer NAKs", reply(), NAK);
        load_in(2'd0, 4'd0);
        chk("R5", "load clears done", in_done, 3'b000);
        token(K_IN, 7'h2A, 2'd0);
        chk("R5", "zero-length sent", reply(), 4);
        chk("R5", "zero-length count", send_len, 0);
        token(K_IN, 7'h2A, 2'd0);
        chk("R5", "zero-length still held", reply(), 4);
        pulse_ack();
        chk("R5", "zero-length acked", in_done, 3'b001);
        token(K_IN, 7'h2A, 2'd0);
        chk("R4", "empty buffer NAK", reply(), NAK);
    endtask

    task automatic t_out_busy();
        int r;
        out_xact(K_OUT, 7'h2A, 2'd0, 1'b1, 1'b1, 4'd5, r);
        chk("R9", "OUT ACK", r, ACK);
        chk("R9", "out_done set", out_done, 1);
        chk("R10", "toggle DATA1", toggle_out, 1);
        chk("R10", "source EP0", out_src, 0);
        chk("R10", "length 5", out_len, 5);
        out_xact(K_OUT, 7'h2A, 2'd0, 1'b1, 1'b0, 4'd2, r);
        chk("R8", "busy OUT NAK", r, NAK);
        chk("R8", "busy length kept", out_len, 5);
        out_xact(K_SETUP, 7'h2A, 2'd0, 1'b1, 1'b0, 4'd8, r);
        chk("R8", "busy SETUP silent", r, NONE);
        chk("R8", "busy setup_flag clear", setup_flag, 0);
        pulse_read();
        chk("R8", "read clears out_done", out_done, 0);
        out_xact(K_OUT, 7'h2A, 2'd0, 1'b0, 1'b0, 4'd3, r);
        chk("R9", "bad CRC silent", r, NONE);
        chk("R9", "bad CRC no done", out_done, 0);
        out_xact(K_OUT, 7'h2A, 2'd0, 1'b1, 1'b0, 4'd12, r);
        chk("R10", "oversize ACK", r, ACK);
        chk("R10", "length saturates", out_len, 8);
        chk("R10", "toggle DATA0", toggle_out, 0);
        pulse_read();
    endtask

    task automatic t_other_endpoints();
        int r;
        cpu_write(2'd0, 8'b0100_0010);
        out_xact(K_OUT, 7'h2A, 2'd2, 1'b1, 1'b1, 4'd2, r);
        chk("R10", "EP2 OUT ACK", r, ACK);
        chk("R10", "source EP2", out_src, 2);
        pulse_read();
        out_xact(K_OUT, 7'h2A, 2'd1, 1'b1, 1'b0, 4'd1, r);
        chk("R3", "EP1 OUT disabled silent", r, NONE);
        token(K_IN, 7'h2A, 2'd1);
        chk("R3", "EP1 IN enabled NAK", reply(), NAK);
    endtask

    task automatic t_stall_and_setup();
        int r;
        cpu_write(2'd1, 8'h16);
        out_xact(K_OUT, 7'h2A, 2'd0, 1'b1, 1'b0, 4'd1, r);
        chk("R6", "EP0 OUT stalled", r, STALL);
        token(K_IN, 7'h2A, 2'd0);
        chk("R6", "EP0 IN not stalled", reply(), NAK);
        token(K_IN, 7'h2A, 2'd1);
        chk("R6", "EP1 IN stalled", reply(), STALL);
        token(K_IN, 7'h2A, 2'd2);
        chk("R6", "EP2 IN disabled stays silent", reply(), NONE);
        out_xact(K_OUT, 7'h2A, 2'd2, 1'b1, 1'b0, 4'd1, r);
        chk("R6", "EP2 OUT stalled", r, STALL);
        out_xact(K_SETUP, 7'h2A, 2'd0, 1'b1, 1'b0, 4'd8, r);
        chk("R7", "SETUP ACK despite OUT stall", r, ACK);
        chk("R7", "setup_flag", setup_flag, 1);
        pulse_read();
        chk("R8", "read clears setup_flag", setup_flag, 0);
        out_xact(K_OUT, 7'h2A, 2'd0, 1'b1, 1'b1, 4'd0, r);
        chk("R7", "EP0 OUT stall released", r, ACK);
        pulse_read();
        token(K_IN, 7'h2A, 2'd1);
        chk("R7", "EP1 stall kept", reply(), STALL);
        cpu_write(2'd1, 8'h01);
        load_in(2'd0, 4'd2);
        token(K_IN, 7'h2A, 2'd0);
        chk("R6", "EP0 IN stall beats data", reply(), STALL);
        load_in(2'd1, 4'd4);
        out_xact(K_SETUP, 7'h2A, 2'd0, 1'b1, 1'b0, 4'd8, r);
        chk("R7", "SETUP ACK", r, ACK);
        token(K_IN, 7'h2A, 2'd0);
        chk("R7", "EP0 flushed and unstalled", reply(), NAK);
        token(K_IN, 7'h2A, 2'd1);
        chk("R7", "EP1 flushed", reply(), NAK);
        pulse_read();
    endtask

    task automatic t_flush_and_rereset();
        load_in(2'd0, 4'd6);
        load_in(2'd1, 4'd1);
        cpu_write(2'd3, 8'h02);
        token(K_IN, 7'h2A, 2'd1);
        chk("R11", "EP1 flushed", reply(), NAK);
        token(K_IN, 7'h2A, 2'd0);
        chk("R11", "EP0 kept", reply(), 4);
        chk("R11", "EP0 length", send_len, 6);
        pulse_bus_reset();
        token(K_IN, 7'd0, 2'd0);
        chk("R2", "bus reset empties EP0", reply(), NAK);
        token(K_IN, 7'd0, 2'd1);
        chk("R2", "bus reset disables EP1", reply(), NONE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_unarmed();
        t_bus_reset_and_address();
        t_in_data();
        t_out_busy();
        t_other_endpoints();
        t_stall_and_setup();
        t_flush_and_rereset();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule